// File: doc/BRIEF.md
# EEPROM Page-Aware Write Sequencer

This block sits on the host side of a serial EEPROM link and stores a run of bytes that starts at any address in the memory. The requester gives a start address and a byte count, then streams the payload over a valid/ready channel. The sequencer cuts the run into pieces so that no piece straddles a 256-byte page. Each piece goes out as a one-byte write-enable frame, followed by a write frame that holds the opcode, a 24-bit address field and the data.

After each write frame the block polls the device status, one short frame at a time, until the busy flag clears. Only then does it move on to the next piece. A poll budget guards against a device that never finishes. A single-cycle `done` marks success and a single-cycle `err` marks a poll timeout.

The serial side runs in SPI mode 0 with a programmable clock divider and a minimum chip-select idle time between frames. Payload bytes are taken from the stream only while a write frame is on the wire, so the requester is held off during polling.

Top module: `eeprom_page_writer`

## Requirements
- R1: A write frame never carries bytes from two pages. The first piece holds min(length, 256 − (start mod 256)) bytes, and every later piece holds min(remaining, 256) bytes. Addresses wrap from the top of the memory to 0.
- R2: Every write frame is preceded by its own frame that carries only the byte 0x06.
- R3: A write frame is the byte 0x02, then three address bytes most significant first with the address in the low 17 bits, then the payload bytes in stream order.
- R4: After each write frame the block sends status frames of two bytes, 0x05 then a 0x00 dummy. Bit 0 of the second byte returned by the device is busy (1) or ready (0). Polling repeats while busy, and the next piece starts only after a ready read.
- R5: If POLL_MAX status reads in a row return busy, the block pulses `err` for one cycle, sends no further frame and returns to idle. POLL_MAX − 1 busy reads followed by a ready read still succeed.
- R6: `done` pulses for one cycle after the ready read that follows the final piece. A request of length 0 pulses `done` and sends no frame.
- R7: `req_ready` is high only while idle. A request presented while a sequence runs is not taken and causes no frames.
- R8: `wr_ready` is high only while chip select is low inside a write frame. It is never high during enable or status frames.
- R9: SPI mode 0: SCK is low while chip select is high. MOSI changes only while SCK is low. Each SCK high phase lasts CLK_DIV clock cycles.
- R10: Chip select stays high for at least CS_GAP clock cycles between frames.
- R11: After reset, chip select is high, SCK is low, `req_ready` is high, and `wr_ready`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of bytes to store |
| wr_data | input | 8 | Payload byte |
| wr_valid | input | 1 | Payload byte valid |
| wr_ready | output | 1 | Payload byte taken this cycle if valid |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle poll timeout pulse |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bench runs a device model that decodes every frame, and a scoreboard that holds the exact byte sequence expected from the page arithmetic. It targets runs that start a few bytes below a page end, a run longer than one page, and a run that wraps past the top address. A design that cut pieces wrongly would put a stray byte or a wrong address byte into a frame. The poll count is driven to one below and well above the budget. An off-by-one budget would then raise `err` on a good write or keep polling after the limit. A request injected mid-sequence, a zero-length request, and stream stalls check that a busy sequencer takes nothing new and pulls payload only inside write frames.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_STATUS = 8'h05;

  typedef enum logic [1:0] {
    B_IDLE,
    B_LOW,
    B_HIGH,
    B_GAP
  } byte_st_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WREN,
    S_OP,
    S_ADDR,
    S_DATA,
    S_POLL_OP,
    S_POLL_RD
  } seq_st_t;

endpackage

// File: rtl/eepw_spi_byte.sv
module eepw_spi_byte
  import eepw_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       last,
  output logic       rdy,
  output logic       bdone,
  output logic [7:0] rx,
  output logic       sck,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GW = $clog2(CS_GAP + 1);
  localparam logic [CW-1:0] CNT_END = CW'(CLK_DIV - 1);
  localparam logic [GW-1:0] GAP_END = GW'(CS_GAP - 1);

  byte_st_t        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [GW-1:0]   gcnt_q, gcnt_d;
  logic [2:0]      bit_q, bit_d;
  logic [7:0]      sh_q, sh_d;
  logic [7:0]      rx_q, rx_d;
  logic            last_q, last_d;
  logic            sck_q, sck_d;
  logic            cs_q, cs_d;
  logic            done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    gcnt_d = gcnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    last_d = last_q;
    sck_d  = sck_q;
    cs_d   = cs_q;
    done_d = 1'b0;
    unique case (st_q)
      B_IDLE: begin
        if (go) begin
          sh_d   = tx;
          last_d = last;
          cs_d   = 1'b0;
          bit_d  = 3'd7;
          cnt_d  = '0;
          st_d   = B_LOW;
        end
      end
      B_LOW: begin
        if (cnt_q == CNT_END) begin
          cnt_d = '0;
          sck_d = 1'b1;
          rx_d  = {rx_q[6:0], miso};
          st_d  = B_HIGH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      B_HIGH: begin
        if (cnt_q == CNT_END) begin
          cnt_d = '0;
          sck_d = 1'b0;
          if (bit_q == 3'd0) begin
            done_d = 1'b1;
            if (last_q) begin
              cs_d   = 1'b1;
              gcnt_d = '0;
              st_d   = B_GAP;
            end else begin
              st_d = B_IDLE;
            end
          end else begin
            bit_d = bit_q - 1'b1;
            sh_d  = {sh_q[6:0], 1'b0};
            st_d  = B_LOW;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      B_GAP: begin
        if (gcnt_q == GAP_END) st_d = B_IDLE;
        else                   gcnt_d = gcnt_q + 1'b1;
      end
      default: st_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      cnt_q  <= '0;
      gcnt_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      last_q <= 1'b0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      gcnt_q <= gcnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      last_q <= last_d;
      sck_q  <= sck_d;
      cs_q   <= cs_d;
      done_q <= done_d;
    end
  end

  assign rdy   = (st_q == B_IDLE);
  assign bdone = done_q;
  assign rx    = rx_q;
  assign sck   = sck_q;
  assign cs_n  = cs_q;
  assign mosi  = sh_q[7];

  // Count of chip-select high cycles, saturating at CS_GAP, for the gap check.
  logic [GW-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_q <= GW'(CS_GAP);
    else if (!cs_q)                     hi_q <= '0;
    else if (hi_q < GW'(CS_GAP))        hi_q <= hi_q + 1'b1;
  end

  p_sck_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sck_q);

  p_mosi_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(sh_q[7]));

  p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (hi_q >= GW'(CS_GAP)));

endmodule

// File: rtl/eepw_seq.sv
module eepw_seq
  import eepw_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int PAGE_W   = 8,
  parameter int LEN_W    = 18,
  parameter int POLL_MAX = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              done,
  output logic              err,
  output logic              sh_go,
  output logic [7:0]        sh_tx,
  output logic              sh_last,
  input  logic              sh_rdy,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx
);

  localparam int ABYTES = (ADDR_W + 7) / 8;
  localparam int AW8    = ABYTES * 8;
  localparam int ABW    = $clog2(ABYTES + 1);
  localparam int SW     = PAGE_W + 1;
  localparam int PCW    = $clog2(POLL_MAX + 1);
  localparam logic [SW-1:0]  PAGE_SZ  = SW'(1 << PAGE_W);
  localparam logic [ABW-1:0] ABYTE_END = ABW'(ABYTES - 1);
  localparam logic [PCW-1:0] POLL_END = PCW'(POLL_MAX - 1);

  seq_st_t           st_q, st_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [SW-1:0]     seg_q, seg_d;
  logic [ABW-1:0]    ab_q, ab_d;
  logic [PCW-1:0]    poll_q, poll_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic              issue;
  logic [SW-1:0]     room, seg_len;
  logic [AW8-1:0]    abus;
  logic [7:0]        abyte;

  always_comb begin
    room    = PAGE_SZ - SW'(addr_q[PAGE_W-1:0]);
    seg_len = (rem_q < LEN_W'(room)) ? SW'(rem_q) : room;
    abus    = AW8'(addr_q);
    abyte   = '0;
    for (int k = 0; k < ABYTES; k++) begin
      if (ab_q == ABW'(k)) abyte = abus[(ABYTES-1-k)*8 +: 8];
    end
  end

  assign issue     = sh_rdy && !pend_q;
  assign req_ready = (st_q == S_IDLE);

  always_comb begin
    st_d    = st_q;
    pend_d  = sh_done ? 1'b0 : pend_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    seg_d   = seg_q;
    ab_d    = ab_q;
    poll_d  = poll_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    sh_go   = 1'b0;
    sh_tx   = '0;
    sh_last = 1'b0;
    wr_ready = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          addr_d = req_addr;
          rem_d  = req_len;
          poll_d = '0;
          if (req_len == '0) done_d = 1'b1;
          else               st_d   = S_WREN;
        end
      end
      S_WREN: begin
        if (issue) begin
          sh_go = 1'b1; sh_tx = OP_WR_EN; sh_last = 1'b1;
          pend_d = 1'b1;
          seg_d  = seg_len;
        end
        if (sh_done) st_d = S_OP;
      end
      S_OP: begin
        if (issue) begin
          sh_go = 1'b1; sh_tx = OP_WRITE;
          pend_d = 1'b1;
        end
        if (sh_done) begin
          ab_d = '0;
          st_d = S_ADDR;
        end
      end
      S_ADDR: begin
        if (issue) begin
          sh_go = 1'b1; sh_tx = abyte;
          pend_d = 1'b1;
        end
        if (sh_done) begin
          if (ab_q == ABYTE_END) st_d = S_DATA;
          else                   ab_d = ab_q + 1'b1;
        end
      end
      S_DATA: begin
        wr_ready = issue && (seg_q != '0);
        if (wr_ready && wr_valid) begin
          sh_go   = 1'b1;
          sh_tx   = wr_data;
          sh_last = (seg_q == SW'(1));
          pend_d  = 1'b1;
          addr_d  = addr_q + 1'b1;
          rem_d   = rem_q - 1'b1;
          seg_d   = seg_q - 1'b1;
        end
        if (sh_done && seg_q == '0) begin
          poll_d = '0;
          st_d   = S_POLL_OP;
        end
      end
      S_POLL_OP: begin
        if (issue) begin
          sh_go = 1'b1; sh_tx = OP_STATUS;
          pend_d = 1'b1;
        end
        if (sh_done) st_d = S_POLL_RD;
      end
      S_POLL_RD: begin
        if (issue) begin
          sh_go = 1'b1; sh_tx = 8'h00; sh_last = 1'b1;
          pend_d = 1'b1;
        end
        if (sh_done) begin
          if (sh_rx[0]) begin
            if (poll_q == POLL_END) begin
              err_d = 1'b1;
              st_d  = S_IDLE;
            end else begin
              poll_d = poll_q + 1'b1;
              st_d   = S_POLL_OP;
            end
          end else if (rem_q == '0) begin
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            st_d = S_WREN;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      seg_q  <= '0;
      ab_q   <= '0;
      poll_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      seg_q  <= seg_d;
      ab_q   <= ab_d;
      poll_q <= poll_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign done = done_q;
  assign err  = err_q;

  // The byte at the top of a page must close its frame.
  p_page_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DATA && sh_go && addr_q[PAGE_W-1:0] == {PAGE_W{1'b1}}) |-> sh_last);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (req_ready && !err_q));

  p_reject_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |=> (rem_q <= $past(rem_q)));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W   = 17,
  parameter int PAGE_W   = 8,
  parameter int LEN_W    = ADDR_W + 1,
  parameter int CLK_DIV  = 2,
  parameter int CS_GAP   = 2,
  parameter int POLL_MAX = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              done,
  output logic              err,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  logic       sh_go, sh_last, sh_rdy, sh_done;
  logic [7:0] sh_tx, sh_rx;

  eepw_seq #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .LEN_W    (LEN_W),
    .POLL_MAX (POLL_MAX)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .done      (done),
    .err       (err),
    .sh_go     (sh_go),
    .sh_tx     (sh_tx),
    .sh_last   (sh_last),
    .sh_rdy    (sh_rdy),
    .sh_done   (sh_done),
    .sh_rx     (sh_rx)
  );

  eepw_spi_byte #(
    .CLK_DIV (CLK_DIV),
    .CS_GAP  (CS_GAP)
  ) u_spi (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (sh_go),
    .tx    (sh_tx),
    .last  (sh_last),
    .rdy   (sh_rdy),
    .bdone (sh_done),
    .rx    (sh_rx),
    .sck   (spi_sck),
    .cs_n  (spi_cs_n),
    .mosi  (spi_mosi),
    .miso  (spi_miso)
  );

  p_pull_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !spi_cs_n);

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (spi_cs_n && req_ready));

endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;

  localparam int ADDR_W   = 17;
  localparam int LEN_W    = 18;
  localparam int CLK_DIV  = 2;
  localparam int CS_GAP   = 3;
  localparam int POLL_MAX = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [7:0]        wr_data = '0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic              done, err;
  logic              spi_sck, spi_cs_n, spi_mosi, spi_miso;

  eeprom_page_writer #(
    .ADDR_W(ADDR_W), .PAGE_W(8), .LEN_W(LEN_W),
    .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_MAX(POLL_MAX)
  ) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .done(done), .err(err),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int pat(int seed, int k);
    return (k * 37 + seed) & 8'hFF;
  endfunction

  // ---------------- device model and scoreboard monitor ----------------
  int       busy_cfg = 0;
  int       busy_left = 0;
  int       bitcnt = 0;
  int       byteidx = 0;
  logic [7:0] shreg = '0;
  logic [7:0] opc = '0;
  logic     cs_prev = 1'b1;
  bit       in_frame = 0;

  assign spi_miso = (opc == 8'h05) && (byteidx == 1) && (bitcnt == 7) && (busy_left > 0);

  always @(posedge spi_sck or posedge spi_cs_n or negedge spi_cs_n) begin
    if (spi_cs_n !== cs_prev) begin
      if (spi_cs_n === 1'b0) begin
        bitcnt = 0; byteidx = 0; opc = 8'h00; in_frame = 1;
      end else if (in_frame) begin
        int e;
        in_frame = 0;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
        chk(bitcnt == 0 && e == -1, "R2 frame end", bitcnt, e);
        if (opc == 8'h02) busy_left = busy_cfg;
        else if (opc == 8'h05 && busy_left > 0) busy_left--;
      end
      cs_prev = spi_cs_n;
    end else if (spi_sck === 1'b1 && spi_cs_n === 1'b0) begin
      shreg = {shreg[6:0], spi_mosi};
      bitcnt++;
      if (bitcnt == 8) begin
        int e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
        chk(e >= 0 && shreg == e[7:0], "R3 R4 frame byte", shreg, e);
        if (byteidx == 0) opc = shreg;
        byteidx++;
        bitcnt = 0;
      end
    end
  end

  // ---------------- signal-level rule watchers ----------------
  int cyc = 0;
  int hi_run = 0;
  int cs_hi_run = 100;
  logic prev_mosi = 1'b0;
  logic prev_sck = 1'b0;
  int v_r8 = 0, v_r9 = 0, v_r10 = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (wr_ready && spi_cs_n) v_r8++;
      if (wr_ready && opc != 8'h02) v_r8++;
      if (spi_cs_n && spi_sck) v_r9++;
      if (spi_sck && prev_sck && spi_mosi !== prev_mosi) v_r9++;
      if (spi_sck) hi_run++;
      else begin
        if (prev_sck && hi_run != CLK_DIV) v_r9++;
        hi_run = 0;
      end
      if (spi_cs_n) cs_hi_run++;
      else begin
        if (cs_hi_run > 0 && cs_hi_run < CS_GAP) v_r10++;
        cs_hi_run = 0;
      end
    end
    prev_sck  = spi_sck;
    prev_mosi = spi_mosi;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- payload stream driver ----------------
  int  feed_len = 0;
  int  feed_idx = 0;
  int  feed_seed = 0;
  bit  gap_mode = 0;
  bit  hs_pend = 0;

  always @(negedge clk) begin
    if (hs_pend) feed_idx++;
    if (feed_idx < feed_len && !(gap_mode && (cyc % 5 == 0))) begin
      wr_valid = 1'b1;
      wr_data  = 8'(pat(feed_seed, feed_idx));
    end else begin
      wr_valid = 1'b0;
    end
    hs_pend = wr_valid && wr_ready;
  end

  // ---------------- request driver: builds the expected frame list ----------------
  task automatic do_req(input int addr, input int len, input int busy,
                        input bit expect_err, input bit intrude, input bit gaps);
    int a, rem, k, seg, room;
    bit got_done, got_err;
    a = addr; rem = len; k = 0;
    while (rem > 0) begin
      room = 256 - (a % 256);
      seg  = (rem < room) ? rem : room;
      exp_q.push_back(8'h06); exp_q.push_back(-1);
      exp_q.push_back(8'h02);
      exp_q.push_back((a >> 16) & 8'hFF);
      exp_q.push_back((a >> 8) & 8'hFF);
      exp_q.push_back(a & 8'hFF);
      for (int j = 0; j < seg; j++) begin
        exp_q.push_back(pat(addr, k));
        k++;
      end
      exp_q.push_back(-1);
      for (int p = 0; p < ((busy >= POLL_MAX) ? POLL_MAX : busy + 1); p++) begin
        exp_q.push_back(8'h05); exp_q.push_back(8'h00); exp_q.push_back(-1);
      end
      if (busy >= POLL_MAX) break;
      a = (a + seg) % (1 << ADDR_W);
      rem -= seg;
    end
    busy_cfg  = busy;
    feed_seed = addr;
    feed_idx  = 0;
    feed_len  = len;
    gap_mode  = gaps;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    got_done = 0; got_err = 0;
    for (int c = 0; c < 60000 && !got_done && !got_err; c++) begin
      if (intrude && c == 40) begin
        chk(req_ready == 1'b0, "R7 busy not ready", req_ready, 0);
        req_valid = 1'b1; req_addr = '0; req_len = LEN_W'(5);
      end
      if (intrude && c == 41) req_valid = 1'b0;
      if (done) got_done = 1;
      if (err) got_err = 1;
      @(negedge clk);
    end
    if (expect_err) begin
      chk(got_err && !got_done, "R5 timeout err", got_err, 1);
    end else begin
      chk(got_done && !got_err, "R6 done seen", got_done, 1);
    end
    chk(done == 1'b0 && err == 1'b0, "R6 single cycle pulse", done | err, 0);
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R2 R4 all expected frames sent", exp_q.size(), 0);
    chk(spi_cs_n == 1'b1, "R5 R6 bus quiet after end", spi_cs_n, 1);
    feed_len = 0;
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(spi_cs_n == 1'b1, "R11 cs_n", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R11 sck", spi_sck, 0);
    chk(req_ready == 1'b1, "R11 req_ready", req_ready, 1);
    chk(wr_ready == 1'b0 && done == 1'b0 && err == 1'b0, "R11 quiet outputs",
        {wr_ready, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_req(32'h000F0, 32, 0, 0, 0, 0);   // R1 split at page end
    do_req(32'h12345, 1, 3, 0, 0, 0);    // R4 three busy polls
    do_req(32'h00100, 300, 1, 0, 0, 1);  // R1 full page then tail, stream stalls
    do_req(32'h1FFFF, 3, 0, 0, 0, 0);    // R1 wrap at top of memory
    do_req(32'h1FFFE, 2, POLL_MAX - 1, 0, 1, 0); // R5 boundary, R7 intrusion
    do_req(32'h00040, 0, 0, 0, 0, 0);    // R6 zero length
    do_req(32'h003FC, 8, 100, 1, 0, 0);  // R5 poll timeout
    do_req(32'h00010, 4, 0, 0, 0, 1);    // recovery after error, R3

    chk(v_r8 == 0, "R8 pull only in write frame", v_r8, 0);
    chk(v_r9 == 0, "R9 mode 0 timing", v_r9, 0);
    chk(v_r10 == 0, "R10 chip select gap", v_r10, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule